// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset and an access kind into a physical byte address, the way a real-mode processor does it. It keeps six 16-bit segment bases. For each access kind it picks one of them as the default. An optional override request may replace that default, but only where the access kind permits it. The selected base is shifted left by four bits, which makes a 16-byte paragraph boundary, and the offset is added to it.

A gate input decides what happens at the top of memory. With the gate asserted, the sum is truncated to 20 bits, so addresses past 1 MiB fold back to the bottom. With the gate deasserted, the carry into bit 20 is kept, and the region just above 1 MiB can be reached. Segment bases are loaded through a simple write port. A translation request is registered and answered one cycle later. The answer also reports which segment base was used.

Top module: `segAddrGen`

## Requirements
- R1: A request accepted on a clock edge makes `addrValid` high after that edge, with `physAddr` = (segment << 4) + offset. Without a request, `addrValid` is low after the edge. Example: segment 06EFh with offset 1234h gives 08124h.
- R2: Access kind 0 (instruction fetch) always uses CS (code 1), and any override is ignored.
- R3: Access kind 1 (stack push/pop) always uses SS (code 2), and any override is ignored.
- R4: Access kind 2 (data addressed through BP) uses SS by default, and a valid override replaces it.
- R5: Access kind 4 (string destination) always uses ES (code 0), and any override is ignored.
- R6: Access kind 3 (string source) uses DS (code 3) by default, and a valid override replaces it.
- R7: Access kind 5 (other data) uses DS by default, and an override can select any of the six bases. Kinds 6 and 7 behave as kind 5. FS (code 4) and GS (code 5) are reached only through an override.
- R8: The segment codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. They are used on `ovrSeg`, `wrIdx` and `segUsed`. An override with code 6 or 7 acts as no override.
- R9: With `gateWrap` high, the sum is truncated to 20 bits and bit 20 reads 0. Examples: FFFFh:0010h gives 00000h, and FFFDh:03E8h gives 003B8h.
- R10: With `gateWrap` low, bit 20 of the sum is kept. Example: FFFFh:FFFFh gives 10FFEFh.
- R11: A write is seen by requests in later cycles only. A request in the same cycle as the write uses the old value. A write with index 6 or 7 changes no base.
- R12: After reset, all bases are 0 except CS, which is FFFFh. The outputs `addrValid`, `physAddr` and `segUsed` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Segment base write strobe |
| wrIdx | input | 3 | Segment code to write |
| wrData | input | 16 | New segment base value |
| reqValid | input | 1 | Translation request |
| accType | input | 3 | Access kind (0 fetch, 1 stack, 2 BP data, 3 string source, 4 string destination, 5 other data) |
| offset | input | 16 | Byte offset within the segment |
| ovrValid | input | 1 | Override request present |
| ovrSeg | input | 3 | Override segment code |
| gateWrap | input | 1 | 1: wrap to 20 bits, 0: keep bit 20 |
| addrValid | output | 1 | Registered result valid |
| physAddr | output | 21 | Registered physical address |
| segUsed | output | 3 | Code of the segment base actually used |

## Verification
The bench uses the default parameters: 16-bit segments and offsets with a 4-bit paragraph shift, which gives a 21-bit result. At these widths, all of the top-of-memory cases from the requirements can be driven exactly. These include the fold to zero, the 952 wrap, and the 10FFEFh ceiling. The six-entry base file lets every override code, including the two unused codes, be tried against every access kind, along with same-cycle write-and-translate collisions.

// File: rtl/segPkg.sv
package segPkg;
  localparam int NUM_SEGS = 6;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } segIdxE;

  typedef enum logic [2:0] {
    ACC_FETCH  = 3'd0,
    ACC_STACK  = 3'd1,
    ACC_BPDATA = 3'd2,
    ACC_STRSRC = 3'd3,
    ACC_STRDST = 3'd4,
    ACC_DATA   = 3'd5
  } accTypeE;

  // strobes from control to datapath
  typedef struct packed {
    logic                load;
    logic                wrapOn;
    logic [SEL_W-1:0]    segSel;
    logic [NUM_SEGS-1:0] wrHot;
  } ctrlStrobeT;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrIdx,
  input  logic             reqValid,
  input  logic [2:0]       accType,
  input  logic             ovrValid,
  input  logic [SEL_W-1:0] ovrSeg,
  input  logic             gateWrap,
  output ctrlStrobeT       strobes
);
  logic                ovrOk;
  logic                mayOverride;
  logic [SEL_W-1:0]    defSeg;
  logic [SEL_W-1:0]    finalSeg;
  logic [NUM_SEGS-1:0] wrHotVec;

  // codes above GS mean "no override"
  assign ovrOk = ovrValid && (ovrSeg < SEL_W'(NUM_SEGS));

  always_comb begin
    case (accType)
      ACC_FETCH:  begin defSeg = SEG_CS; mayOverride = 1'b0; end
      ACC_STACK:  begin defSeg = SEG_SS; mayOverride = 1'b0; end
      ACC_BPDATA: begin defSeg = SEG_SS; mayOverride = 1'b1; end
      ACC_STRSRC: begin defSeg = SEG_DS; mayOverride = 1'b1; end
      ACC_STRDST: begin defSeg = SEG_ES; mayOverride = 1'b0; end
      default:    begin defSeg = SEG_DS; mayOverride = 1'b1; end
    endcase
  end

  assign finalSeg = (mayOverride && ovrOk) ? ovrSeg : defSeg;

  genvar g;
  generate
    for (g = 0; g < NUM_SEGS; g++) begin : gWrDec
      assign wrHotVec[g] = wrEn && (wrIdx == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    strobes.load   = reqValid;
    strobes.wrapOn = gateWrap;
    strobes.segSel = finalSeg;
    strobes.wrHot  = wrHotVec;
  end

  // R5: string destination stays on ES
  a_r5_dst_es: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == ACC_STRDST) |-> strobes.segSel == SEG_ES);

  // R8: unused override codes fall back to the default for plain data
  a_r8_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ovrValid && ovrSeg >= 3'd6 && accType == ACC_DATA) |-> strobes.segSel == SEG_DS);

  // R11: at most one base written per cycle
  a_r11_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrHot));
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int SEG_W    = 16,
  parameter int OFF_W    = 16,
  parameter int SHIFT    = 4,
  parameter logic [SEG_W-1:0] CS_RESET = '1,
  localparam int BASE_W  = SEG_W + SHIFT,
  localparam int ADDR_W  = BASE_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [SEG_W-1:0]  wrData,
  input  logic [OFF_W-1:0]  offset,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [SEL_W-1:0]  segUsed
);
  logic [SEG_W-1:0]  segRegs [NUM_SEGS];
  logic [SEG_W-1:0]  selBase;
  logic [ADDR_W-1:0] baseExt;
  logic [ADDR_W-1:0] rawSum;
  logic [ADDR_W-1:0] gatedSum;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (!rstN)
        segRegs[i] <= (i == int'(SEG_CS)) ? CS_RESET : '0;
      else if (strobes.wrHot[i])
        segRegs[i] <= wrData;
    end
  end

  assign selBase  = segRegs[strobes.segSel];
  assign baseExt  = {1'b0, selBase, {SHIFT{1'b0}}};
  assign rawSum   = baseExt + ADDR_W'(offset);
  assign gatedSum = strobes.wrapOn ? {1'b0, rawSum[BASE_W-1:0]} : rawSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      physAddr  <= '0;
      segUsed   <= '0;
    end else begin
      addrValid <= strobes.load;
      if (strobes.load) begin
        physAddr <= gatedSum;
        segUsed  <= strobes.segSel;
      end
    end
  end

  // R9: wrapped results never carry into the top bit
  a_r9_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.wrapOn) |=> !physAddr[BASE_W]);

  // R11: a DS write lands on the next edge
  a_r11_ds_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHot[SEG_DS] |=> segRegs[SEG_DS] == $past(wrData));
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segPkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  localparam int ADDR_W = SEG_W + SHIFT + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrIdx,
  input  logic [SEG_W-1:0]  wrData,
  input  logic              reqValid,
  input  logic [2:0]        accType,
  input  logic [OFF_W-1:0]  offset,
  input  logic              ovrValid,
  input  logic [2:0]        ovrSeg,
  input  logic              gateWrap,
  output logic              addrValid,
  output logic [ADDR_W-1:0] physAddr,
  output logic [2:0]        segUsed
);
  ctrlStrobeT strobes;

  segCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx),
    .reqValid(reqValid), .accType(accType), .ovrValid(ovrValid),
    .ovrSeg(ovrSeg), .gateWrap(gateWrap), .strobes(strobes)
  );

  segDatapath #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .offset(offset), .addrValid(addrValid), .physAddr(physAddr),
    .segUsed(segUsed)
  );

  // R1: one-cycle answer to every request
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  // R2: fetches report CS
  a_r2_fetch_cs: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == ACC_FETCH) |=> segUsed == SEG_CS);

  // R3: stack accesses report SS
  a_r3_stack_ss: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == ACC_STACK) |=> segUsed == SEG_SS);

  // R7: FS/GS only after an override request
  a_r7_fsgs_override: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && segUsed >= 3'd4) |-> $past(ovrValid));
endmodule

// File: tb/segAddrGen_tb.sv
module segAddrGen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrIdx;
  logic [15:0] wrData;
  logic        reqValid;
  logic [2:0]  accType;
  logic [15:0] offset;
  logic        ovrValid;
  logic [2:0]  ovrSeg;
  logic        gateWrap;
  logic        addrValid;
  logic [20:0] physAddr;
  logic [2:0]  segUsed;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] mdl [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  segAddrGen u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .reqValid(reqValid), .accType(accType), .offset(offset),
    .ovrValid(ovrValid), .ovrSeg(ovrSeg), .gateWrap(gateWrap),
    .addrValid(addrValid), .physAddr(physAddr), .segUsed(segUsed)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expSel(input logic [2:0] at, input bit ov, input logic [2:0] oc);
    bit ok = ov && (oc < 3'd6);
    case (at)
      3'd0: return 3'd1;
      3'd1: return 3'd2;
      3'd2: return ok ? oc : 3'd2;
      3'd4: return 3'd0;
      default: return ok ? oc : 3'd3;
    endcase
  endfunction

  function automatic logic [20:0] expAddr(input logic [15:0] seg, input logic [15:0] off, input bit gw);
    logic [20:0] s = {1'b0, seg, 4'b0} + {5'b0, off};
    return gw ? {1'b0, s[19:0]} : s;
  endfunction

  // called at a negedge; ends at the following negedge
  task automatic step(input bit we, input logic [2:0] wi, input logic [15:0] wd,
                      input bit rv, input logic [2:0] at, input logic [15:0] off,
                      input bit ov, input logic [2:0] oc, input bit gw, input string tag);
    logic [2:0]  s;
    logic [20:0] a;
    s = expSel(at, ov, oc);
    a = expAddr(mdl[s], off, gw);
    wrEn = we; wrIdx = wi; wrData = wd;
    reqValid = rv; accType = at; offset = off;
    ovrValid = ov; ovrSeg = oc; gateWrap = gw;
    @(negedge clk);
    if (rv) begin
      chk({tag, " valid"}, {31'b0, addrValid}, 32'd1);
      chk({tag, " seg"}, {29'b0, segUsed}, {29'b0, s});
      chk({tag, " addr"}, {11'b0, physAddr}, {11'b0, a});
    end else begin
      chk({tag, " idle"}, {31'b0, addrValid}, 32'd0);
    end
    if (we && wi < 3'd6) mdl[wi] = wd;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; wrEn = 0; wrIdx = 0; wrData = 0; reqValid = 0; accType = 0;
    offset = 0; ovrValid = 0; ovrSeg = 0; gateWrap = 0;
    for (int i = 0; i < 6; i++) mdl[i] = (i == 1) ? 16'hFFFF : 16'h0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset outputs
    chk("R12 valid", {31'b0, addrValid}, 0);
    chk("R12 addr", {11'b0, physAddr}, 0);
    chk("R12 seg", {29'b0, segUsed}, 0);
    // R12 reset bases read back through overrides
    for (int c = 0; c < 6; c++) step(0, 0, 0, 1, 3'd5, 16'h0, 1, 3'(c), 0, "R12");
    // R1 paragraph math
    step(1, 3'd3, 16'h06EF, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 3'd5, 16'h1234, 0, 0, 1, "R1");
    idle();
    // R9 wrap cases via string destination
    step(1, 3'd0, 16'hFFFF, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 3'd4, 16'h0010, 0, 0, 1, "R9");
    chk("R9 fold", {11'b0, physAddr}, 32'h0);
    step(1, 3'd0, 16'hFFFD, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 3'd4, 16'h03E8, 0, 0, 1, "R9");
    chk("R9 952", {11'b0, physAddr}, 32'h3B8);
    // R10 carry kept
    step(0, 0, 0, 1, 3'd0, 16'hFFFF, 0, 0, 0, "R10");
    chk("R10 top", {11'b0, physAddr}, 32'h10FFEF);
    step(0, 0, 0, 1, 3'd0, 16'hFFFF, 0, 0, 1, "R9");
    // R2 R3 R5 overrides ignored
    step(1, 3'd2, 16'h1230, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 3'd4, 16'h4000, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 3'd5, 16'h5000, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 3'd0, 16'h0042, 1, 3'd0, 0, "R2");
    step(0, 0, 0, 1, 3'd1, 16'h0042, 1, 3'd4, 0, "R3");
    step(0, 0, 0, 1, 3'd4, 16'h0042, 1, 3'd3, 0, "R5");
    // R4 R6 R7 overrides honoured
    step(0, 0, 0, 1, 3'd2, 16'h0100, 0, 0, 0, "R4");
    step(0, 0, 0, 1, 3'd2, 16'h0100, 1, 3'd4, 0, "R4");
    step(0, 0, 0, 1, 3'd3, 16'h0200, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 3'd3, 16'h0200, 1, 3'd5, 0, "R6");
    step(0, 0, 0, 1, 3'd5, 16'h0300, 1, 3'd4, 0, "R7");
    step(0, 0, 0, 1, 3'd7, 16'h0300, 0, 0, 0, "R7");
    // R8 unused codes
    step(0, 0, 0, 1, 3'd5, 16'h0400, 1, 3'd6, 0, "R8");
    step(0, 0, 0, 1, 3'd2, 16'h0400, 1, 3'd7, 0, "R8");
    // R11 same-cycle write uses the old base, next cycle the new one
    step(1, 3'd3, 16'hABCD, 1, 3'd5, 16'h0010, 0, 0, 0, "R11");
    step(0, 0, 0, 1, 3'd5, 16'h0010, 0, 0, 0, "R11");
    // R11 out-of-range write index changes nothing
    step(1, 3'd6, 16'h7777, 0, 0, 0, 0, 0, 0, "R11");
    step(1, 3'd7, 16'h8888, 0, 0, 0, 0, 0, 0, "R11");
    for (int c = 0; c < 6; c++) step(0, 0, 0, 1, 3'd5, 16'h0, 1, 3'(c), 0, "R11");
    // random mix
    for (int n = 0; n < 600; n++) begin
      step(($urandom % 4) == 0, 3'($urandom), 16'($urandom),
           ($urandom % 5) != 0, 3'($urandom), 16'($urandom),
           $urandom % 2, 3'($urandom), $urandom % 2, "R1 random");
    end
    idle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule